// File: doc/BRIEF.md
# Programmable Cascadable Down Counter

This block is a 4-bit binary down counter, clocked entirely by the system clock, that can be preset and chained with other instances. Counting is requested through two level inputs of opposite sense. Both are synchronised and edge-detected. One input requests a step on its rising edge, and only while the other input is LOW. The other requests a step on its falling edge, and only while the first input is HIGH. Each input therefore inhibits the other. A load control copies a 4-bit preset into the counter. A master clear forces the counter to zero and overrides everything else.

A decoded terminal-count output flags the all-zero state. It is qualified by a cascade input and masked while a load is in progress. Several instances can be chained this way: the terminal count of a lower digit feeds the cascade input of the next digit, so that only the top digit reports that the whole chain has reached zero. A parameter selects divide-by-n mode. In that mode terminal count drives the load internally, and the block divides the count-edge rate by the preset value.

No data stream passes through the block, so it has no valid/ready handshake. All pins are plain control and status signals. The four control pins (both count inputs, load and clear) each pass through a two-stage synchroniser. A requested step is applied in the cycle after its edge is detected. The preset and cascade inputs are treated as quasi-static and are not synchronised.

Top module: `prog_down_ctr`

## Requirements
- R1: While the synchronised clear is HIGH, the count goes to 0 and stays there, even if load is HIGH and count edges arrive.
- R2: While load is HIGH and clear is LOW, the count equals the preset, and edges on either count input have no effect on it.
- R3: With load LOW and the falling-sense input LOW, each rising edge of the rising-sense input lowers the count by one.
- R4: With load LOW and the rising-sense input HIGH, each falling edge of the falling-sense input lowers the count by one.
- R5: An edge on either count input while the other input is at its inhibiting level does not change the count. Inhibiting levels are HIGH on the falling-sense input and LOW on the rising-sense input.
- R6: The sequence is plain binary descending. One step from 0 gives 15.
- R7: Terminal count is HIGH exactly when the count is 0, cascade is HIGH and the synchronised load is LOW.
- R8: In divide-by-n mode with a preset p from 1 to 15 and cascade HIGH, terminal count is HIGH for exactly one system-clock cycle every p count edges. The preset is reloaded in that cycle, so the count returns to p.
- R9: In divide-by-n mode with a preset of 0, the count stays at 0 and terminal count stays HIGH while count edges arrive.
- R10: Two free-running instances can be chained as a two-digit counter. The count input drives the low digit. The low digit's terminal count drives both the high digit's falling-sense input and its cascade input, and the high digit's rising-sense input is held HIGH. The pair then counts 16*high+low down by one per count edge, and the high digit's terminal count goes HIGH only at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset for every flop |
| cnt_rise_i | input | 1 | Count request acted on at its rising edge; inhibits the other input while LOW |
| cnt_fall_i | input | 1 | Count request acted on at its falling edge; inhibits the other input while HIGH |
| load_i | input | 1 | Load request; count follows preset while HIGH |
| clear_i | input | 1 | Master clear, highest priority |
| preset_i | input | WIDTH | Value copied into the counter on load or internal reload |
| cascade_i | input | 1 | Qualifier for terminal count |
| count_o | output | WIDTH | Current count |
| tc_o | output | 1 | Terminal count, decoded from zero, cascade and load |

## Verification
The hardest condition to reach is in divide-by-n mode: the zero state lasts only one system cycle before the reload. Terminal count must be shown to be a single-cycle pulse that does not repeat. A monitor samples terminal count on every falling clock edge and counts the HIGH cycles and any back-to-back HIGH cycles over three full periods for several presets. The chained pair is also hard to exercise, because a carry has to cross two synchronisers and two step registers before the high digit moves. The count edges are spaced widely enough that each carry settles, and after every edge the pair is compared with a decrementing reference value.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic {
    PDC_FREE_RUN = 1'b0,
    PDC_DIVIDE_N = 1'b1
  } pdc_mode_e;

  // control pins carried through the synchroniser as one vector
  typedef struct packed {
    logic rise;
    logic fall;
    logic load;
    logic clear;
  } pdc_ctl_t;

  localparam int unsigned PDC_CTL_BITS = $bits(pdc_ctl_t);
endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/pdc_step.sv
module pdc_step (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_s,
  input  logic fall_s,
  output logic step_o
);
  logic rise_d, fall_d;
  logic rise_edge, fall_edge, step_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_d <= 1'b0;
      fall_d <= 1'b0;
    end else begin
      rise_d <= rise_s;
      fall_d <= fall_s;
    end
  end

  assign rise_edge = rise_s & ~rise_d;
  assign fall_edge = fall_d & ~fall_s;
  // each input counts only while the other sits at its enabling level
  assign step_d = (rise_edge & ~fall_s) | (fall_edge & rise_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_o <= 1'b0;
    else        step_o <= step_d;
  end
endmodule

// File: rtl/pdc_core.sv
module pdc_core
  import pdc_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter pdc_mode_e   MODE  = PDC_FREE_RUN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_s,
  input  logic             load_s,
  input  logic             step,
  input  logic [WIDTH-1:0] preset_i,
  input  logic             cascade_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  logic [WIDTH-1:0] count_q;
  logic             at_zero;
  logic             reload;

  assign at_zero = (count_q == '0);
  assign tc_o    = at_zero & cascade_i & ~load_s;

  if (MODE == PDC_DIVIDE_N) begin : g_div
    assign reload = load_s | tc_o;

    // R8
    single_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_o && !clear_s && preset_i != '0) |=> !tc_o);
  end else begin : g_free
    assign reload = load_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (clear_s) count_q <= '0;
    else if (reload)  count_q <= preset_i;
    else if (step)    count_q <= count_q - 1'b1;
  end

  assign count_o = count_q;

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_s |=> (count_o == '0));

  // R2
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_s && !clear_s) |=> (count_o == $past(preset_i)));

  // R3
  step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear_s && !reload) |=> (count_o == $past(count_o) - 1'b1));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear_s && !reload) |=> $stable(count_o));

  // R6
  wrap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear_s && !reload && count_o == '0) |=> (&count_o));
endmodule

// File: rtl/prog_down_ctr.sv
module prog_down_ctr
  import pdc_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter pdc_mode_e   MODE        = PDC_FREE_RUN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_rise_i,
  input  logic             cnt_fall_i,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [WIDTH-1:0] preset_i,
  input  logic             cascade_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  pdc_ctl_t ctl_raw, ctl_s;
  logic     step;

  assign ctl_raw = '{rise: cnt_rise_i, fall: cnt_fall_i, load: load_i, clear: clear_i};

  pdc_sync #(.WIDTH(PDC_CTL_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ctl_raw),
    .sync_o  (ctl_s)
  );

  pdc_step u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_s (ctl_s.rise),
    .fall_s (ctl_s.fall),
    .step_o (step)
  );

  pdc_core #(.WIDTH(WIDTH), .MODE(MODE)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_s   (ctl_s.clear),
    .load_s    (ctl_s.load),
    .step      (step),
    .preset_i  (preset_i),
    .cascade_i (cascade_i),
    .count_o   (count_o),
    .tc_o      (tc_o)
  );
endmodule

// File: tb/test_prog_down_ctr.sv
module test_prog_down_ctr;
  import pdc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // main free-running instance
  logic m_rise = 0, m_fall = 0, m_load = 0, m_clr = 0, m_casc = 1;
  logic [3:0] m_preset = 0, m_count;
  logic m_tc;

  prog_down_ctr i_prog_down_ctr (
    .clk(clk), .rst_n(rst_n), .cnt_rise_i(m_rise), .cnt_fall_i(m_fall),
    .load_i(m_load), .clear_i(m_clr), .preset_i(m_preset), .cascade_i(m_casc),
    .count_o(m_count), .tc_o(m_tc));

  // divide-by-n instance
  logic d_rise = 0, d_clr = 0;
  logic [3:0] d_preset = 0, d_count;
  logic d_tc;

  prog_down_ctr #(.MODE(PDC_DIVIDE_N)) i_div (
    .clk(clk), .rst_n(rst_n), .cnt_rise_i(d_rise), .cnt_fall_i(1'b0),
    .load_i(1'b0), .clear_i(d_clr), .preset_i(d_preset), .cascade_i(1'b1),
    .count_o(d_count), .tc_o(d_tc));

  // two-digit chain
  logic c_clk = 0, c_load = 1, hi_rise = 1;
  logic [3:0] c_pl = 0, c_ph = 0, lo_count, hi_count;
  logic lo_tc, hi_tc;

  prog_down_ctr i_lo (
    .clk(clk), .rst_n(rst_n), .cnt_rise_i(c_clk), .cnt_fall_i(1'b0),
    .load_i(c_load), .clear_i(1'b0), .preset_i(c_pl), .cascade_i(1'b1),
    .count_o(lo_count), .tc_o(lo_tc));

  prog_down_ctr i_hi (
    .clk(clk), .rst_n(rst_n), .cnt_rise_i(hi_rise), .cnt_fall_i(lo_tc),
    .load_i(c_load), .clear_i(1'b0), .preset_i(c_ph), .cascade_i(lo_tc),
    .count_o(hi_count), .tc_o(hi_tc));

  // terminal-count monitor for the divider
  bit mon_clr = 1'b1;
  int mon_hi = 0, mon_dbl = 0;
  logic mon_prev = 1'b0;
  always @(negedge clk) begin
    if (mon_clr) begin
      mon_hi <= 0; mon_dbl <= 0; mon_prev <= 1'b0;
    end else begin
      if (d_tc) mon_hi <= mon_hi + 1;
      if (d_tc && mon_prev) mon_dbl <= mon_dbl + 1;
      mon_prev <= d_tc;
    end
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // vector: [15:13] op, [12:9] data, [8:5] count, [4] tc, [3:0] requirement
  localparam logic [2:0] OP_CLR = 0, OP_LOAD = 1, OP_RISE = 2, OP_FALL = 3,
                         OP_INH = 4, OP_CASC = 5;
  localparam int NV = 15;
  localparam logic [15:0] VECS [NV] = '{
    {OP_LOAD, 4'd3, 4'd3,  1'b0, 4'd2},  // R2 load, edges ignored
    {OP_RISE, 4'd0, 4'd2,  1'b0, 4'd3},  // R3
    {OP_FALL, 4'd0, 4'd1,  1'b0, 4'd4},  // R4
    {OP_INH,  4'd0, 4'd1,  1'b0, 4'd5},  // R5 both inhibited edges
    {OP_RISE, 4'd0, 4'd0,  1'b1, 4'd7},  // R7 zero with cascade
    {OP_CASC, 4'd0, 4'd0,  1'b0, 4'd7},  // R7 cascade low masks
    {OP_CASC, 4'd1, 4'd0,  1'b1, 4'd7},  // R7
    {OP_RISE, 4'd0, 4'd15, 1'b0, 4'd6},  // R6 wrap
    {OP_FALL, 4'd0, 4'd14, 1'b0, 4'd4},  // R4
    {OP_LOAD, 4'd0, 4'd0,  1'b0, 4'd7},  // R7 load masks tc
    {OP_FALL, 4'd0, 4'd15, 1'b0, 4'd6},  // R6
    {OP_CLR,  4'd9, 4'd0,  1'b0, 4'd1},  // R1 clear beats load
    {OP_LOAD, 4'd1, 4'd1,  1'b0, 4'd2},  // R2
    {OP_INH,  4'd0, 4'd1,  1'b0, 4'd5},  // R5
    {OP_RISE, 4'd0, 4'd0,  1'b1, 4'd3}   // R3
  };

  task automatic apply_op(input logic [2:0] op, input logic [3:0] data);
    case (op)
      OP_CLR:  begin m_preset = data; m_load = 1; m_clr = 1; end
      OP_LOAD: begin m_preset = data; m_load = 1; wcyc(4); m_rise = 1; wcyc(5); m_rise = 0; end
      OP_RISE: begin m_rise = 1; wcyc(5); m_rise = 0; end
      OP_FALL: begin m_fall = 1; wcyc(5); m_rise = 1; wcyc(5); m_fall = 0; wcyc(5); m_rise = 0; end
      OP_INH:  begin m_fall = 1; wcyc(5); m_rise = 1; wcyc(5); m_rise = 0; wcyc(5); m_fall = 0; end
      default: m_casc = data[0];
    endcase
    wcyc(6);
  endtask

  task automatic div_case(input logic [3:0] p);
    d_preset = p; d_clr = 1; wcyc(6); d_clr = 0; wcyc(8);
    chk("R8 reload after clear", d_count, p);
    mon_clr = 0;
    for (int e = 0; e < 3 * p; e++) begin
      d_rise = 1; wcyc(5); d_rise = 0; wcyc(5);
    end
    wcyc(4);
    mon_clr = 1;
    chk("R8 tc cycles in three periods", mon_hi, 3);
    chk("R8 back-to-back tc cycles", mon_dbl, 0);
    chk("R8 count after full periods", d_count, p);
  endtask

  task automatic chain_case(input logic [3:0] hi, input logic [3:0] lo);
    int v;
    c_ph = hi; c_pl = lo; c_load = 1; wcyc(6); c_load = 0; wcyc(8);
    v = hi * 16 + lo;
    chk("R10 chain preset", {hi_count, lo_count}, v);
    while (v > 0) begin
      c_clk = 1; wcyc(12); c_clk = 0; wcyc(12);
      v--;
      chk("R10 chain value", {hi_count, lo_count}, v);
      chk("R10 chain terminal", hi_tc, (v == 0) ? 1 : 0);
    end
  endtask

  initial begin
    wcyc(5);
    rst_n = 1;
    wcyc(6);
    chk("R1 reset count", m_count, 0);
    chk("R7 reset tc", m_tc, 1);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VECS[i];
      apply_op(v[15:13], v[12:9]);
      chk($sformatf("R%0d vec%0d count", v[3:0], i), m_count, v[8:5]);
      chk($sformatf("R%0d vec%0d tc", v[3:0], i), m_tc, v[4]);
      if (v[15:13] == OP_CLR || v[15:13] == OP_LOAD) begin
        m_load = 0; m_clr = 0; wcyc(6);
      end
    end

    // R6 long descending run across a wrap, R7 tc tracks zero
    m_preset = 5; m_load = 1; wcyc(6); m_load = 0; wcyc(6);
    for (int e = 1; e <= 20; e++) begin
      int exp_c;
      m_rise = 1; wcyc(5); m_rise = 0; wcyc(6);
      exp_c = (5 - e + 32) % 16;
      chk("R6 run count", m_count, exp_c);
      chk("R7 run tc", m_tc, (exp_c == 0) ? 1 : 0);
    end

    // R8 divide by preset
    div_case(4'd1);
    div_case(4'd5);
    div_case(4'd15);

    // R9 preset zero: no operation
    d_preset = 0; d_clr = 1; wcyc(6); d_clr = 0; wcyc(8);
    for (int e = 0; e < 5; e++) begin
      d_rise = 1; wcyc(5); d_rise = 0; wcyc(5);
    end
    chk("R9 count held at zero", d_count, 0);
    chk("R9 tc held high", d_tc, 1);

    // R10 two-digit chain
    chain_case(4'd3, 4'd10);
    chain_case(4'd2, 4'd0);

    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      summary();
    end
  end
endmodule